// File: doc/BRIEF.md
# Serial ROM Identifier CRC Checker

This block takes in a 64-bit device identifier one bit at a time and checks it. It builds the identifier in a capture register. Over the first 56 received bits it runs an 8-bit cyclic redundancy check with generator x^8 + x^5 + x^4 + 1. The last 8 bits are the stored check byte. Once the 64th bit is in, the block compares that byte with the computed value exactly as received, with no complement.

Bits arrive least significant bit first, so the check register works in reflected form. Each accepted payload bit is XORed with register bit 0. The register then shifts right, and it is XORed with 0x8C when that feedback bit is 1. The register starts from 0x00.

A second check register runs over all 64 bits. For a consistent identifier it must end at zero. The block uses this second register to cross-check the compare result. A start pulse clears everything and begins a new identifier. Bits that arrive after the 64th are ignored until the next start.

Top module: `rom_id_crc_check`

## Requirements
- R1: After reset, and in the cycle after a start pulse, done_o and match_o are 0, crc_o is 0x00 and id_o is all zeros.
- R2: The k-th accepted bit (k = 0..63, counted from the last start) lands in id_o bit k. After 64 bits, id_o equals the transmitted identifier.
- R3: After 56 accepted bits, crc_o equals the reflected CRC of those bits. For each bit b: fb = crc[0] ^ b, crc = crc >> 1, and crc ^= 0x8C when fb is 1. Initial value is 0x00.
- R4: Bits 56 to 63 do not change crc_o.
- R5: done_o is high for exactly one cycle: the cycle after the clock edge that accepts the 64th bit.
- R6: match_o is high only while done_o is high. It is 1 exactly when id_o[63:56] equals crc_o with no inversion. This is equivalent to the CRC over all 64 bits being zero.
- R7: Once 64 bits are accepted, further bit_vld_i strobes change neither id_o nor crc_o and raise no done_o, until the next start.
- R8: start_i takes priority over a bit strobed in the same cycle. That bit is discarded and the frame restarts from bit 0.
- R9: Cycles with bit_vld_i low do not advance reception. Idle gaps between bits give the same result as back-to-back bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clears the checker and begins a new identifier |
| bit_vld_i | input | 1 | Strobe: bit_i holds a received bit this cycle |
| bit_i | input | 1 | Serial identifier bit, least significant first |
| done_o | output | 1 | One-cycle pulse after the 64th bit |
| match_o | output | 1 | Check byte agreed with computed CRC (valid with done_o) |
| crc_o | output | 8 | CRC computed over the 56-bit payload |
| id_o | output | 64 | Captured identifier |

## Verification
The assertions assume that start_i and bit_vld_i are synchronous single-cycle qualifiers. They also assume bit_i is meaningful only while bit_vld_i is high. Neither input is allowed to depend on done_o within the same cycle. The stimulus drives all inputs on the falling clock edge. It sends frames with random idle gaps, and it sends extra strobes after a complete frame. It raises start_i together with a bit strobe in the middle of a frame, to reach the priority and ignore cases. Half of the random frames carry a correct check byte and half carry a corrupted one, so both outcomes of the compare are exercised.

// File: rtl/crcid_pkg.sv
package crcid_pkg;
   parameter int unsigned DEF_ID_W  = 64;
   parameter int unsigned DEF_CRC_W = 8;
   parameter logic [7:0]  DEF_POLY  = 8'h8C;   // reflected x^8+x^5+x^4+1
endpackage

// File: rtl/crcid_bitcnt.sv
module crcid_bitcnt #(
   parameter int unsigned ID_W  = 64,
   parameter int unsigned PAY_W = 56,
   localparam int unsigned CNT_W = $clog2(ID_W + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic vld_i,
   output logic accept_o,
   output logic in_payload_o,
   output logic last_o,
   output logic full_o
);
   logic [CNT_W-1:0] cnt_q;

   assign full_o       = (cnt_q == CNT_W'(ID_W));
   assign accept_o     = vld_i && !full_o && !clr_i;
   assign in_payload_o = (cnt_q < CNT_W'(PAY_W));
   assign last_o       = accept_o && (cnt_q == CNT_W'(ID_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (clr_i)    cnt_q <= '0;
      else if (accept_o) cnt_q <= cnt_q + 1'b1;
   end

   assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(ID_W));
   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!vld_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/crcid_lfsr.sv
module crcid_lfsr #(
   parameter int unsigned        W         = 8,
   parameter logic [W-1:0]       POLY      = 8'h8C,
   parameter bit                 REFLECTED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         en_i,
   input  logic         din_i,
   output logic [W-1:0] crc_o
);
   logic [W-1:0] crc_q, crc_nx;
   logic         fb;

   generate
      if (REFLECTED) begin : g_refl
         assign fb     = crc_q[0] ^ din_i;
         assign crc_nx = (crc_q >> 1) ^ (fb ? POLY : '0);
      end else begin : g_norm
         assign fb     = crc_q[W-1] ^ din_i;
         assign crc_nx = (crc_q << 1) ^ (fb ? POLY : '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc_q <= '0;
      else if (clr_i) crc_q <= '0;
      else if (en_i)  crc_q <= crc_nx;
   end

   assign crc_o = crc_q;
endmodule

// File: rtl/crcid_shreg.sv
module crcid_shreg #(
   parameter int unsigned W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         en_i,
   input  logic         din_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] q_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_q <= '0;
      else if (clr_i) q_q <= '0;
      else if (en_i)  q_q <= {din_i, q_q[W-1:1]};
   end

   assign q_o = q_q;
endmodule

// File: rtl/rom_id_crc_check.sv
module rom_id_crc_check
   import crcid_pkg::*;
#(
   parameter int unsigned          ID_W      = DEF_ID_W,
   parameter int unsigned          CRC_W     = DEF_CRC_W,
   parameter logic [CRC_W-1:0]     POLY      = DEF_POLY,
   parameter bit                   REFLECTED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             bit_vld_i,
   input  logic             bit_i,
   output logic             done_o,
   output logic             match_o,
   output logic [CRC_W-1:0] crc_o,
   output logic [ID_W-1:0]  id_o
);
   localparam int unsigned PAY_W = ID_W - CRC_W;

   generate
      if (CRC_W < 1 || ID_W <= CRC_W) begin : g_bad_width
         $error("rom_id_crc_check: ID_W must exceed CRC_W");
      end
      if (REFLECTED == 1'b0) begin : g_order_note
         if (CRC_W > 32) begin : g_bad_crc
            $error("rom_id_crc_check: CRC_W too wide");
         end
      end
   endgenerate

   logic             accept, in_pay, last, full;
   logic [CRC_W-1:0] crc_pay, crc_res;
   logic [ID_W-1:0]  id_q;
   logic             done_q;

   crcid_bitcnt #(.ID_W(ID_W), .PAY_W(PAY_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(start_i), .vld_i(bit_vld_i),
      .accept_o(accept), .in_payload_o(in_pay), .last_o(last), .full_o(full));

   crcid_lfsr #(.W(CRC_W), .POLY(POLY), .REFLECTED(REFLECTED)) u_pay (
      .clk(clk), .rst_n(rst_n), .clr_i(start_i), .en_i(accept && in_pay),
      .din_i(bit_i), .crc_o(crc_pay));

   crcid_lfsr #(.W(CRC_W), .POLY(POLY), .REFLECTED(REFLECTED)) u_res (
      .clk(clk), .rst_n(rst_n), .clr_i(start_i), .en_i(accept),
      .din_i(bit_i), .crc_o(crc_res));

   crcid_shreg #(.W(ID_W)) u_id (
      .clk(clk), .rst_n(rst_n), .clr_i(start_i), .en_i(accept),
      .din_i(bit_i), .q_o(id_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= last && !start_i;
   end

   assign done_o  = done_q;
   assign match_o = done_q && (crc_pay == id_q[ID_W-1 -: CRC_W]);
   assign crc_o   = crc_pay;
   assign id_o    = id_q;

   assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (crc_pay == '0 && id_q == '0 && !done_q));
   assert_crc_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_pay && !start_i) |=> $stable(crc_pay));
   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   assert_match_qual_R6: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |-> done_q);
   assert_match_residue_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (match_o == (crc_res == '0)));
   assert_ignore_after_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !start_i) |=> ($stable(id_q) && !done_q));
endmodule

// File: tb/test_rom_id_crc_check.sv
module test_rom_id_crc_check;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        bit_vld_i = 1'b0;
   logic        bit_i = 1'b0;
   logic        done_o, match_o;
   logic [7:0]  crc_o;
   logic [63:0] id_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rom_id_crc_check i_rom_id_crc_check (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_vld_i(bit_vld_i),
      .bit_i(bit_i), .done_o(done_o), .match_o(match_o), .crc_o(crc_o), .id_o(id_o));

   function automatic logic [7:0] ref_crc(input logic [63:0] v, input int n);
      logic [7:0] c;
      logic       fb;
      c = 8'h00;
      for (int i = 0; i < n; i++) begin
         fb = c[0] ^ v[i];
         c  = c >> 1;
         if (fb) c = c ^ 8'h8C;
      end
      return c;
   endfunction

   function automatic logic [63:0] make_id(input logic [55:0] pay, input bit good);
      logic [7:0] c;
      logic [7:0] flip;
      c = ref_crc({8'h00, pay}, 56);
      flip = 8'($urandom_range(1, 255));
      return {good ? c : (c ^ flip), pay};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start_i   = 1'b1;
      bit_vld_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      chk("R1", "crc after start", 64'(crc_o), 64'h0);
      chk("R1", "id after start", id_o, 64'h0);
   endtask

   task automatic send_frame(input logic [63:0] v, input int gapmax);
      logic exp_match;
      for (int i = 0; i < 64; i++) begin
         int gap = (gapmax > 0) ? $urandom_range(0, gapmax) : 0;
         repeat (gap) begin
            @(negedge clk);
            bit_vld_i = 1'b0;
         end
         @(negedge clk);
         if (i == 56) chk("R3", "crc after 56 bits", 64'(crc_o), 64'(ref_crc(v, 56)));
         if (i > 0) chk("R5", "done mid-frame", 64'(done_o), 64'h0);
         bit_vld_i = 1'b1;
         bit_i     = v[i];
      end
      @(negedge clk);
      bit_vld_i = 1'b0;
      exp_match = (v[63:56] == ref_crc(v, 56));
      chk("R5", "done after bit 64", 64'(done_o), 64'h1);
      chk("R6", "match", 64'(match_o), 64'(exp_match));
      chk("R6", "compare vs residue agree", 64'(exp_match), 64'(ref_crc(v, 64) == 8'h00));
      chk("R2", "captured id", id_o, v);
      chk("R4", "crc held over check byte", 64'(crc_o), 64'(ref_crc(v, 56)));
      @(negedge clk);
      chk("R5", "done one cycle only", 64'(done_o), 64'h0);
      chk("R6", "match outside done", 64'(match_o), 64'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] v;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R1", "done in reset", 64'(done_o), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "crc at reset", 64'(crc_o), 64'h0);
      chk("R1", "id at reset", id_o, 64'h0);
      chk("R1", "match at reset", 64'(match_o), 64'h0);

      // all-zero identifier: CRC zero, matches
      pulse_start();
      send_frame(64'h0, 0);

      // known identifier with check byte 0xA2
      pulse_start();
      v = 64'hA200_0000_01B8_1C02;
      chk("R3", "known vector ref", 64'(ref_crc(v, 56)), 64'hA2);
      send_frame(v, 0);

      // inverted check byte must not match (R6: no inversion)
      pulse_start();
      v = {~8'hA2, 56'h00_0000_01B8_1C02};
      send_frame(v, 1);

      // random frames, good and corrupted, with idle gaps (R9)
      for (int f = 0; f < 40; f++) begin
         pulse_start();
         send_frame(make_id(56'({$urandom, $urandom}), (f % 2) == 0), f % 4);
      end

      // R7: extra strobes after 64 bits are ignored
      pulse_start();
      v = make_id(56'({$urandom, $urandom}), 1'b1);
      send_frame(v, 0);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         bit_vld_i = 1'b1;
         bit_i     = ~v[k];
      end
      @(negedge clk);
      bit_vld_i = 1'b0;
      chk("R7", "id after extra bits", id_o, v);
      chk("R7", "crc after extra bits", 64'(crc_o), 64'(ref_crc(v, 56)));
      chk("R7", "no done after extra bits", 64'(done_o), 64'h0);
      @(negedge clk);
      chk("R7", "no late done", 64'(done_o), 64'h0);

      // R8: start together with a bit strobe mid-frame
      pulse_start();
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         bit_vld_i = 1'b1;
         bit_i     = 1'b1;
      end
      @(negedge clk);
      start_i   = 1'b1;
      bit_vld_i = 1'b1;
      bit_i     = 1'b1;
      @(negedge clk);
      start_i   = 1'b0;
      bit_vld_i = 1'b0;
      chk("R8", "crc after start+bit", 64'(crc_o), 64'h0);
      chk("R8", "id after start+bit", id_o, 64'h0);
      v = make_id(56'({$urandom, $urandom}), 1'b1);
      send_frame(v, 2);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule